// File: doc/BRIEF.md
# Four-Strike Watchdog with Guarded Disable

This peripheral combines a microsecond tick timer with a watchdog countdown. The tick timer divides a 1 MHz enable pulse by a programmed number of microseconds and produces one firing per interval. It runs either once or in auto-reload mode. Each firing lowers the watchdog countdown by one. When the countdown runs out it reloads from the programmed period and bumps a strike counter. The fourth run-out ends the countdown and, if allowed, raises a one-cycle system reset request.

Software arms and keeps the watchdog alive with the same start command. It can read the live countdown and strike count to work out the time left, which is (3 − strikes) × period + count timer firings. Stopping the watchdog needs two writes: a key written to the unlock register, then the disable command. Without the key, a disable attempt does nothing.

The watchdog core is a four-state machine:

- `WS_IDLE`: stopped.
- `WS_COUNT`: counting down.
- `WS_FIRE`: the single cycle in which the reset request is driven.
- `WS_HALT`: stopped after the fourth strike.

Its transitions are:

- **start**: IDLE, COUNT, FIRE or HALT go to COUNT.
- **guarded stop**: COUNT, FIRE or HALT go to IDLE.
- **fourth strike with reset enabled**: COUNT goes to FIRE.
- **fourth strike with reset disabled**: COUNT goes to HALT.
- **fire done**: FIRE goes to HALT.

Top module: `wdog_top`

## Requirements
- R1: After reset, every register reads 0, `irq` and `rst_req` are low, and the watchdog is stopped.
- R2: The timer register (byte offset 0x10) uses bit 31 as enable, bit 30 as auto-reload and bits 23:0 as the period in tick pulses. While enabled with a nonzero period it fires once per period ticks. In one-shot mode it clears bit 31 after firing. Writing 0 stops it.
- R3: The config register (offset 0x0) keeps the timer index in bits 3:0, the watchdog period in bits 11:4, interrupt enable in bit 12 and reset enable in bit 15. All other bits read 0.
- R4: Writing bit 0 of the command register (offset 0x8) loads the countdown with the period and clears the strike count. The status register (offset 0x4) shows the countdown in bits 11:4 and the strike count in bits 13:12.
- R5: Each timer firing while counting decrements the countdown. A firing at countdown 1 instead reloads the period and increments the strike count.
- R6: On the fourth run-out with reset enabled, `rst_req` is high for exactly one cycle. The block then halts with status count 0 and strikes 3, and ignores further firings until a start command.
- R7: On the fourth run-out with reset enable clear, `rst_req` stays low and the block halts in the same way.
- R8: `irq` rises on the first run-out when interrupt enable is set. It then stays high until a start command or an accepted disable, and it never rises while interrupt enable is clear.
- R9: Writing 0xC45A in bits 15:0 of the unlock register (offset 0xC) arms the guard, which reads back as bit 0. Any other unlock value disarms it, and every command write disarms it.
- R10: Bit 1 of a command write stops the watchdog, freezing the status, only if the guard is armed. Otherwise it has no effect. An accepted disable takes priority over a start bit in the same write.
- R11: A start command while counting restores the full period and strike count 0, acting as the keep-alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle 1 MHz time-base enable |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt from the first run-out |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is the one-cycle window of the reset request. It follows three full reloads and must be caught exactly in the cycle after the last timer firing. The stimulus sets both the timer interval and the watchdog period to 1, so that each tick pulse is one strike. It then walks single ticks up to the fourth and samples `rst_req` and the status register on the cycle after that firing and on the cycle after that.

The guarded disable is reached through ordered bus writes. These are key then disable, wrong key then disable, and key consumed by a start then disable. The countdown is read after each sequence, so an ignored disable shows up as continued counting.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_COUNT = 2'd1,
        WS_FIRE  = 2'd2,
        WS_HALT  = 2'd3
    } wd_state_t;

    localparam logic [7:0]  OFF_CFG    = 8'h00;
    localparam logic [7:0]  OFF_STS    = 8'h04;
    localparam logic [7:0]  OFF_CMD    = 8'h08;
    localparam logic [7:0]  OFF_UNLOCK = 8'h0C;
    localparam logic [7:0]  OFF_TMR    = 8'h10;
    localparam logic [15:0] GUARD_KEY  = 16'hC45A;
    localparam int          STRIKE_W   = 2;

endpackage

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer #(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        tick_1us,
    output logic [31:0] ctrl_o,
    output logic        fire
);
    localparam int PAD_W = 30 - TMR_W;

    logic             en_q;
    logic             auto_q;
    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] cnt_q;
    logic             live;

    assign live = en_q && (period_q != '0);
    assign fire = live && tick_1us && (cnt_q == period_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            auto_q   <= 1'b0;
            period_q <= '0;
            cnt_q    <= '0;
        end else if (we) begin
            en_q     <= wdata[31];
            auto_q   <= wdata[30];
            period_q <= wdata[TMR_W-1:0];
            cnt_q    <= '0;
        end else if (fire) begin
            cnt_q <= '0;
            if (!auto_q) begin
                en_q <= 1'b0;
            end
        end else if (live && tick_1us) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ctrl_o = {en_q, auto_q, {PAD_W{1'b0}}, period_q};

    // R2
    cnt_below_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (cnt_q < period_q));

    // R2
    oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !auto_q && !we) |=> !en_q);

endmodule

// File: rtl/wdog_cmd_gate.sv
module wdog_cmd_gate
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        unl_we,
    input  logic        cmd_we,
    input  logic [15:0] wdata,
    output logic        armed,
    output logic        start,
    output logic        stop
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (unl_we) begin
            armed_q <= (wdata == GUARD_KEY);
        end else if (cmd_we) begin
            armed_q <= 1'b0;
        end
    end

    assign stop  = cmd_we && wdata[1] && armed_q;
    assign start = cmd_we && wdata[0] && !stop;
    assign armed = armed_q;

    // R9
    cmd_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !unl_we) |=> !armed_q);

    // R10
    no_stop_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !stop);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    period,
    input  logic                int_en,
    input  logic                rst_en,
    input  logic                start,
    input  logic                stop,
    input  logic                tick,
    output logic [CNT_W-1:0]    count_o,
    output logic [STRIKE_W-1:0] strikes_o,
    output logic                irq,
    output logic                rst_req
);
    localparam logic [STRIKE_W-1:0] LAST_STRIKE = '1;

    wd_state_t             state_q, state_d;
    logic [CNT_W-1:0]      count_q;
    logic [STRIKE_W-1:0]   strikes_q;
    logic                  irq_q;
    logic                  runout;
    logic                  final_runout;

    assign runout       = (state_q == WS_COUNT) && tick && (count_q <= 1);
    assign final_runout = runout && (strikes_q == LAST_STRIKE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (start) state_d = WS_COUNT;
            end
            WS_COUNT: begin
                if (stop)              state_d = WS_IDLE;
                else if (start)        state_d = WS_COUNT;
                else if (final_runout) state_d = rst_en ? WS_FIRE : WS_HALT;
            end
            WS_FIRE: begin
                if (stop)       state_d = WS_IDLE;
                else if (start) state_d = WS_COUNT;
                else            state_d = WS_HALT;
            end
            WS_HALT: begin
                if (stop)       state_d = WS_IDLE;
                else if (start) state_d = WS_COUNT;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // countdown and strike datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            strikes_q <= '0;
        end else if (start && !stop) begin
            count_q   <= period;
            strikes_q <= '0;
        end else if (!stop && final_runout) begin
            count_q <= '0;
        end else if (!stop && runout) begin
            count_q   <= period;
            strikes_q <= strikes_q + 1'b1;
        end else if (!stop && (state_q == WS_COUNT) && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    // interrupt latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (start || stop) begin
            irq_q <= 1'b0;
        end else if (runout && (strikes_q == '0) && int_en) begin
            irq_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rst_req   = (state_q == WS_FIRE);
        irq       = irq_q;
        count_o   = count_q;
        strikes_o = strikes_q;
    end

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6
    fire_to_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !start && !stop) |=> (state_q == WS_HALT));

    // R6
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_HALT) && !start && !stop) |=> ($stable(count_q) && $stable(strikes_q)));

    // R5
    strike_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_COUNT) && !start) |=> (strikes_q >= $past(strikes_q)));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(int_en));

    // R10
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == WS_IDLE) && !irq_q);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int TMR_W  = 24,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam int CNT_LSB = IDX_W;
    localparam int CNT_MSB = IDX_W + CNT_W - 1;
    localparam int IEN_BIT = CNT_MSB + 1;
    localparam int REN_BIT = IEN_BIT + 3;
    localparam int STK_LSB = CNT_MSB + 1;

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_UNL = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFF_TMR);

    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    period_q;
    logic                int_en_q;
    logic                rst_en_q;

    logic                cfg_we, cmd_we, unl_we, tmr_we;
    logic                armed, start, stop, fire;
    logic [31:0]         tmr_ctrl;
    logic [CNT_W-1:0]    count;
    logic [STRIKE_W-1:0] strikes;

    assign cfg_we = bus_we && (bus_addr == A_CFG);
    assign cmd_we = bus_we && (bus_addr == A_CMD);
    assign unl_we = bus_we && (bus_addr == A_UNL);
    assign tmr_we = bus_we && (bus_addr == A_TMR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            period_q <= '0;
            int_en_q <= 1'b0;
            rst_en_q <= 1'b0;
        end else if (cfg_we) begin
            idx_q    <= bus_wdata[IDX_W-1:0];
            period_q <= bus_wdata[CNT_MSB:CNT_LSB];
            int_en_q <= bus_wdata[IEN_BIT];
            rst_en_q <= bus_wdata[REN_BIT];
        end
    end

    wdog_tick_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tmr_we),
        .wdata    (bus_wdata),
        .tick_1us (tick_1us),
        .ctrl_o   (tmr_ctrl),
        .fire     (fire)
    );

    wdog_cmd_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .unl_we (unl_we),
        .cmd_we (cmd_we),
        .wdata  (bus_wdata[15:0]),
        .armed  (armed),
        .start  (start),
        .stop   (stop)
    );

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (period_q),
        .int_en    (int_en_q),
        .rst_en    (rst_en_q),
        .start     (start),
        .stop      (stop),
        .tick      (fire),
        .count_o   (count),
        .strikes_o (strikes),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CFG) begin
            bus_rdata[IDX_W-1:0]       = idx_q;
            bus_rdata[CNT_MSB:CNT_LSB] = period_q;
            bus_rdata[IEN_BIT]         = int_en_q;
            bus_rdata[REN_BIT]         = rst_en_q;
        end else if (bus_addr == A_STS) begin
            bus_rdata[CNT_MSB:CNT_LSB]              = count;
            bus_rdata[STK_LSB+STRIKE_W-1:STK_LSB]   = strikes;
        end else if (bus_addr == A_UNL) begin
            bus_rdata[0] = armed;
        end else if (bus_addr == A_TMR) begin
            bus_rdata = tmr_ctrl;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!irq && !rst_req));

endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1us  (tick_1us),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    typedef struct packed {
        logic [1:0]  op;   // 0 write, 1 read-compare, 2 ticks, 3 irq-compare
        logic [4:0]  adr;
        logic [31:0] dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t VECS [NV] = '{
        {2'd0, 5'h10, 32'hC000_0001, 4'd2},  // R2 timer every tick
        {2'd0, 5'h00, 32'h0000_9035, 4'd3},
        {2'd1, 5'h00, 32'h0000_9035, 4'd3},  // R3
        {2'd0, 5'h00, 32'hFFFF_FFFF, 4'd3},
        {2'd1, 5'h00, 32'h0000_9FFF, 4'd3},  // R3 only fields stick
        {2'd0, 5'h00, 32'h0000_9035, 4'd3},
        {2'd0, 5'h08, 32'h0000_0001, 4'd4},
        {2'd1, 5'h04, 32'h0000_0030, 4'd4},  // R4
        {2'd2, 5'h00, 32'd1,         4'd5},
        {2'd1, 5'h04, 32'h0000_0020, 4'd5},  // R5
        {2'd2, 5'h00, 32'd2,         4'd5},
        {2'd1, 5'h04, 32'h0000_1030, 4'd5},  // R5 reload
        {2'd3, 5'h00, 32'd1,         4'd8},  // R8 irq up
        {2'd2, 5'h00, 32'd1,         4'd11},
        {2'd0, 5'h08, 32'h0000_0001, 4'd11},
        {2'd1, 5'h04, 32'h0000_0030, 4'd11}, // R11 kick
        {2'd3, 5'h00, 32'd0,         4'd8},  // R8 start clears
        {2'd0, 5'h08, 32'h0000_0002, 4'd10},
        {2'd2, 5'h00, 32'd1,         4'd10},
        {2'd1, 5'h04, 32'h0000_0020, 4'd10}, // R10 unarmed ignored
        {2'd0, 5'h0C, 32'h0000_1234, 4'd9},
        {2'd1, 5'h0C, 32'h0000_0000, 4'd9},  // R9
        {2'd0, 5'h0C, 32'h0000_C45A, 4'd9},
        {2'd1, 5'h0C, 32'h0000_0001, 4'd9},  // R9 armed
        {2'd0, 5'h08, 32'h0000_0001, 4'd9},
        {2'd1, 5'h0C, 32'h0000_0000, 4'd9},  // R9 consumed
        {2'd0, 5'h08, 32'h0000_0002, 4'd10},
        {2'd2, 5'h00, 32'd1,         4'd10},
        {2'd1, 5'h04, 32'h0000_0020, 4'd10}, // R10
        {2'd0, 5'h0C, 32'h0000_C45A, 4'd9},
        {2'd0, 5'h0C, 32'h0000_0001, 4'd9},
        {2'd1, 5'h0C, 32'h0000_0000, 4'd9},  // R9 wrong key
        {2'd2, 5'h00, 32'd2,         4'd5},
        {2'd1, 5'h04, 32'h0000_1030, 4'd5},
        {2'd3, 5'h00, 32'd1,         4'd8},
        {2'd0, 5'h0C, 32'h0000_C45A, 4'd10},
        {2'd0, 5'h08, 32'h0000_0002, 4'd10},
        {2'd3, 5'h00, 32'd0,         4'd8},  // R8 disable clears
        {2'd2, 5'h00, 32'd3,         4'd10},
        {2'd1, 5'h04, 32'h0000_1030, 4'd10}, // R10 frozen
        {2'd0, 5'h00, 32'h0000_0025, 4'd7},
        {2'd0, 5'h08, 32'h0000_0001, 4'd7},
        {2'd2, 5'h00, 32'd8,         4'd7},
        {2'd1, 5'h04, 32'h0000_3000, 4'd7},  // R7 halted
        {2'd3, 5'h00, 32'd0,         4'd8},
        {2'd2, 5'h00, 32'd2,         4'd7},
        {2'd1, 5'h04, 32'h0000_3000, 4'd7},
        {2'd0, 5'h00, 32'h0000_0035, 4'd4},
        {2'd0, 5'h08, 32'h0000_0001, 4'd4},
        {2'd1, 5'h04, 32'h0000_0030, 4'd4},  // R4 restart from halt
        {2'd0, 5'h10, 32'h8000_0002, 4'd2},
        {2'd2, 5'h00, 32'd2,         4'd2},
        {2'd1, 5'h04, 32'h0000_0020, 4'd2},
        {2'd1, 5'h10, 32'h0000_0002, 4'd2},  // R2 one-shot cleared enable
        {2'd2, 5'h00, 32'd4,         4'd2},
        {2'd1, 5'h04, 32'h0000_0020, 4'd2},
        {2'd0, 5'h10, 32'hC000_0002, 4'd2},
        {2'd2, 5'h00, 32'd3,         4'd2},
        {2'd1, 5'h04, 32'h0000_0010, 4'd2},
        {2'd0, 5'h10, 32'h0000_0000, 4'd2},
        {2'd2, 5'h00, 32'd4,         4'd2},
        {2'd1, 5'h04, 32'h0000_0010, 4'd2},  // R2 stopped
        {2'd1, 5'h10, 32'h0000_0000, 4'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1us = 1'b1;
            @(negedge clk);
            tick_1us = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            unique case (VECS[i].op)
                2'd0: wr(VECS[i].adr, VECS[i].dat);
                2'd1: begin rd(VECS[i].adr, v); check(tag, v, VECS[i].dat); end
                2'd2: ticks(int'(VECS[i].dat));
                default: check(tag, {31'b0, irq}, VECS[i].dat);
            endcase
        end
        check("R7 no reset pulse", 32'(pulses), 32'd0);

        // R6 fourth strike with reset enabled, period 1
        wr(5'h10, 32'hC000_0001);
        wr(5'h00, 32'h0000_8015);
        wr(5'h08, 32'h0000_0001);
        ticks(3);
        rd(5'h04, v); check("R6 before final", v, 32'h0000_3010);
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
        check("R6 rst_req high", {31'b0, rst_req}, 32'h1);
        rd(5'h04, v); check("R6 halt status", v, 32'h0000_3000);
        @(negedge clk);
        check("R6 rst_req one cycle", {31'b0, rst_req}, 32'h0);
        ticks(3);
        rd(5'h04, v); check("R6 ignores ticks", v, 32'h0000_3000);
        check("R6 pulse count", 32'(pulses), 32'd1);
        wr(5'h08, 32'h0000_0001);
        rd(5'h04, v); check("R11 restart", v, 32'h0000_0010);

        // R10 disable wins over start in the same write
        wr(5'h0C, 32'h0000_C45A);
        wr(5'h08, 32'h0000_0003);
        ticks(2);
        rd(5'h04, v); check("R10 disable priority", v, 32'h0000_0010);

        // R1 mid-run reset
        wr(5'h08, 32'h0000_0001);
        rst_n = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), v);
            check("R1 after reset", v, 32'h0);
        end
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule